// File: doc/BRIEF.md
# Dual-Channel Phase Clock Generator

This block derives the cycle-start timing for two switching-regulator channels from one fast reference clock. A period counter divides the reference clock by N = 4·Q ticks, where Q is a run-time quarter-period value, and emits a one-tick start pulse for channel 1 at the beginning of every period. Channel 2 receives its own one-tick start pulse, placed at a phase offset from channel 1 that a small mode decode selects.

The decode looks at two static configuration inputs. The first says whether the pair is working as a tracking memory supply, where channel 2 follows channel 1. The second says how the input supply is set up: battery feedforward, or a two-step stage fed from a regulated 5 V rail. In tracking mode with battery feed, the channels start together. In tracking mode with two-step feed, channel 2 lags by a quarter period. When tracking mode is off, the channels act as independent regulators half a period apart. In tracking mode the block also raises a flag that bars channel 2 from light-load hysteretic operation.

All configuration, including Q, is sampled only at channel-1 period boundaries. A change therefore never shortens, stretches or duplicates a pulse inside a running period. A reference clock near 100 MHz with Q around 83 gives a switching rate close to 300 kHz.

Top module: `phase_clkgen`

## Requirements
- R1: While `rst` is high, `ch1_start_o`, `ch2_start_o` and `ch2_hyst_inhibit_o` are low.
- R2: `ch1_start_o` pulses high for exactly one reference tick, once every 4·Q ticks, where Q is the latched `quarter_i`.
- R3: With `track_mode_i`=1 and `supply_twostep_i`=0 (battery feed), `ch2_start_o` is high in the same tick as `ch1_start_o` (0° offset).
- R4: With `track_mode_i`=1 and `supply_twostep_i`=1 (two-step feed), `ch2_start_o` is high Q ticks after `ch1_start_o` (90° offset).
- R5: With `track_mode_i`=0, `ch2_start_o` is high 2·Q ticks after `ch1_start_o` (180° offset), whatever the value of `supply_twostep_i`.
- R6: `ch2_start_o` is a one-tick pulse that occurs exactly once in every channel-1 period.
- R7: `ch2_hyst_inhibit_o` equals the latched `track_mode_i`. It is updated in the same tick as the channel-1 pulse that opens the period using that setting.
- R8: A change on `track_mode_i` or `supply_twostep_i` within a period does not affect that period. It takes effect from the next channel-1 pulse.
- R9: A change on `quarter_i` within a period leaves that period's length unchanged. The next period uses the new value.
- R10: A `quarter_i` value of 0 is treated as 1, giving a 4-tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset; also samples the configuration inputs |
| track_mode_i | input | 1 | 1 = channel 2 tracks channel 1 (memory supply mode), 0 = independent channels |
| supply_twostep_i | input | 1 | 1 = two-step conversion from a regulated 5 V rail, 0 = battery feedforward |
| quarter_i | input | QW | Quarter-period length Q in reference ticks; period is 4·Q |
| ch1_start_o | output | 1 | One-tick cycle-start pulse for channel 1 |
| ch2_start_o | output | 1 | One-tick cycle-start pulse for channel 2 |
| ch2_hyst_inhibit_o | output | 1 | High when channel 2 must stay out of hysteretic operation |

## Verification
The hardest situation to reach from the ports is a configuration change arriving partway through a period. The block is built so that such a change has no visible effect until the next channel-1 pulse. To exercise this, the stimulus first locks onto a channel-1 pulse. It then changes the mode or Q a few ticks into the period. It checks that the rest of that period still shows the old channel-2 offset, the old length and the old inhibit flag, and that the new setting appears exactly at the following boundary. A table of static configurations, including a zero Q and settings where the supply input should be ignored, covers the decode.

// File: rtl/phase_clkgen_pkg.sv
package phase_clkgen_pkg;

  // Phase relation of channel 2 against channel 1
  typedef enum logic [1:0] {
    PH_ALIGNED = 2'd0,  // 0 degrees
    PH_QUARTER = 2'd1,  // 90 degrees, Q ticks
    PH_HALF    = 2'd2   // 180 degrees, 2Q ticks
  } phase_sel_e;

  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/pcg_mode_decode.sv
module pcg_mode_decode
  import phase_clkgen_pkg::*;
(
  input  logic       track_i,
  input  logic       twostep_i,
  output phase_sel_e sel_o
);

  always_comb begin
    if (!track_i)       sel_o = PH_HALF;
    else if (twostep_i) sel_o = PH_QUARTER;
    else                sel_o = PH_ALIGNED;
  end

endmodule

// File: rtl/pcg_cfg_latch.sv
module pcg_cfg_latch
  import phase_clkgen_pkg::*;
#(
  parameter int unsigned QW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrap_i,
  input  logic          track_i,
  input  phase_sel_e    sel_i,
  input  logic [QW-1:0] quarter_i,
  output logic          track_q,
  output phase_sel_e    sel_q,
  output logic [QW-1:0] quarter_q
);

  logic [QW-1:0] quarter_safe;

  assign quarter_safe = (quarter_i == '0) ? QW'(1) : quarter_i;

  always_ff @(posedge clk) begin
    if (rst || wrap_i) begin
      track_q   <= track_i;
      sel_q     <= sel_i;
      quarter_q <= quarter_safe;
    end
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap_i |=> ($stable(sel_q) && $stable(track_q) && $stable(quarter_q)));

  // R10
  quarter_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    quarter_q != '0);

endmodule

// File: rtl/pcg_period_counter.sv
module pcg_period_counter #(
  parameter int unsigned QW = 8,
  localparam int unsigned CW = QW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [QW-1:0] quarter_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);

  logic [CW-1:0] period_len;
  logic [CW-1:0] last_tick;
  logic [CW-1:0] cnt_q;

  assign period_len = {quarter_i, 2'b00};
  assign last_tick  = period_len - CW'(1);
  assign wrap_o     = (cnt_q == last_tick);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_tick);

  // R2
  wrap_restart_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0));

endmodule

// File: rtl/pcg_pulse_gen.sv
module pcg_pulse_gen
  import phase_clkgen_pkg::*;
#(
  parameter int unsigned QW = 8,
  localparam int unsigned CW = QW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     cnt_i,
  input  phase_sel_e        sel_i,
  input  logic [QW-1:0]     quarter_i,
  input  logic              track_i,
  output logic [NUM_CH-1:0] start_o,
  output logic              hyst_inh_o
);

  logic [CW-1:0] ofs [NUM_CH];
  logic          hyst_q;

  assign ofs[0] = '0;

  always_comb begin
    unique case (sel_i)
      PH_QUARTER: ofs[1] = {2'b00, quarter_i};
      PH_HALF:    ofs[1] = {1'b0, quarter_i, 1'b0};
      default:    ofs[1] = '0;
    endcase
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic pulse_q;
    always_ff @(posedge clk) begin
      if (rst) pulse_q <= 1'b0;
      else     pulse_q <= (cnt_i == ofs[c]);
    end
    assign start_o[c] = pulse_q;

    // R2 R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
      pulse_q |=> !pulse_q);
  end

  always_ff @(posedge clk) begin
    if (rst) hyst_q <= 1'b0;
    else     hyst_q <= track_i;
  end
  assign hyst_inh_o = hyst_q;

  // R3
  aligned_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start_o[0] && ($past(sel_i) == PH_ALIGNED)) |-> start_o[1]);

endmodule

// File: rtl/phase_clkgen.sv
module phase_clkgen
  import phase_clkgen_pkg::*;
#(
  parameter int unsigned QW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          track_mode_i,
  input  logic          supply_twostep_i,
  input  logic [QW-1:0] quarter_i,
  output logic          ch1_start_o,
  output logic          ch2_start_o,
  output logic          ch2_hyst_inhibit_o
);

  localparam int unsigned CW = QW + 2;

  phase_sel_e          sel_dec;
  phase_sel_e          sel_q;
  logic                track_q;
  logic [QW-1:0]       quarter_q;
  logic [CW-1:0]       cnt;
  logic                wrap;
  logic [NUM_CH-1:0]   starts;

  pcg_mode_decode u_decode (
    .track_i   (track_mode_i),
    .twostep_i (supply_twostep_i),
    .sel_o     (sel_dec)
  );

  pcg_cfg_latch #(.QW(QW)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .wrap_i    (wrap),
    .track_i   (track_mode_i),
    .sel_i     (sel_dec),
    .quarter_i (quarter_i),
    .track_q   (track_q),
    .sel_q     (sel_q),
    .quarter_q (quarter_q)
  );

  pcg_period_counter #(.QW(QW)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .quarter_i (quarter_q),
    .cnt_o     (cnt),
    .wrap_o    (wrap)
  );

  pcg_pulse_gen #(.QW(QW)) u_pulse (
    .clk        (clk),
    .rst        (rst),
    .cnt_i      (cnt),
    .sel_i      (sel_q),
    .quarter_i  (quarter_q),
    .track_i    (track_q),
    .start_o    (starts),
    .hyst_inh_o (ch2_hyst_inhibit_o)
  );

  assign ch1_start_o = starts[0];
  assign ch2_start_o = starts[1];

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!ch1_start_o && !ch2_start_o && !ch2_hyst_inhibit_o));

endmodule

// File: tb/phase_clkgen_tb.sv
module phase_clkgen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int QW = 8;
  localparam int NV = 7;
  // [31]=track [30]=twostep [23:16]=Q [15:8]=expected offset [7:0]=expected period
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 1'b0, 6'd0, 8'd4, 8'd0,  8'd16},
    {1'b1, 1'b1, 6'd0, 8'd4, 8'd4,  8'd16},
    {1'b0, 1'b0, 6'd0, 8'd4, 8'd8,  8'd16},
    {1'b0, 1'b1, 6'd0, 8'd5, 8'd10, 8'd20},
    {1'b1, 1'b1, 6'd0, 8'd7, 8'd7,  8'd28},
    {1'b0, 1'b0, 6'd0, 8'd0, 8'd2,  8'd4},
    {1'b1, 1'b0, 6'd0, 8'd3, 8'd0,  8'd12}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic track = 1'b0;
  logic twostep = 1'b0;
  logic [QW-1:0] quarter = 8'd4;
  logic ch1, ch2, hyst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_clkgen #(.QW(QW)) u_dut (
    .clk                (clk),
    .rst                (rst),
    .track_mode_i       (track),
    .supply_twostep_i   (supply_twostep_wire),
    .quarter_i          (quarter),
    .ch1_start_o        (ch1),
    .ch2_start_o        (ch2),
    .ch2_hyst_inhibit_o (hyst)
  );

  logic supply_twostep_wire;
  assign supply_twostep_wire = twostep;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic tr, input logic ts, input logic [QW-1:0] q);
    @(negedge clk);
    rst = 1'b1; track = tr; twostep = ts; quarter = q;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_ch1();
    for (int i = 0; i < 2000; i++) begin
      if (ch1) return;
      @(negedge clk);
    end
    check(1'b0, "R2 no channel-1 pulse", 0, 1);
  endtask

  // Called at a negedge showing ch1; scans one period.
  task automatic scan(output int per, output int off, output int n2, output bit hy);
    hy = hyst; per = -1; off = -1; n2 = 0;
    for (int t = 0; t < 1200; t++) begin
      if (t > 0 && ch1) begin per = t; return; end
      if (ch2) begin n2++; if (off < 0) off = t; end
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int per, off, n2;
    bit hy;

    // R1: outputs quiet during reset
    do_reset(1'b1, 1'b0, 8'd4);
    rst = 1'b1;
    @(negedge clk);
    check(!ch1 && !ch2 && !hyst, "R1 reset outputs", {ch1, ch2, hyst}, 0);
    rst = 1'b0;

    // Table of static configurations
    for (int v = 0; v < NV; v++) begin
      do_reset(VEC[v][31], VEC[v][30], VEC[v][23:16]);
      wait_ch1();
      scan(per, off, n2, hy);
      check(per == int'(VEC[v][7:0]), "R2 R10 period", per, int'(VEC[v][7:0]));
      check(off == int'(VEC[v][15:8]), "R3 R4 R5 channel-2 offset", off, int'(VEC[v][15:8]));
      check(n2 == 1, "R6 channel-2 pulses per period", n2, 1);
      check(hy == VEC[v][31], "R7 hysteretic inhibit", int'(hy), int'(VEC[v][31]));
    end

    // R5: supply input ignored when tracking is off, changed mid-period
    do_reset(1'b0, 1'b0, 8'd4);
    wait_ch1();
    @(negedge clk);
    twostep = 1'b1;
    wait_ch1();
    scan(per, off, n2, hy);
    check(off == 8, "R5 supply ignored in independent mode", off, 8);

    // R8: mode change mid-period applies at next boundary
    do_reset(1'b0, 1'b0, 8'd4);
    wait_ch1();
    @(negedge clk);
    @(negedge clk);
    track = 1'b1;
    begin
      int first2;
      bit hy_mid;
      first2 = -1; hy_mid = 1'b1;
      for (int t = 2; t < 40; t++) begin
        if (ch1) break;
        if (ch2 && first2 < 0) begin first2 = t; hy_mid = hyst; end
        @(negedge clk);
      end
      check(first2 == 8, "R8 old offset kept in running period", first2, 8);
      check(hy_mid == 1'b0, "R8 R7 inhibit unchanged mid-period", int'(hy_mid), 0);
      check(ch1 && ch2, "R8 R3 new aligned phase at boundary", {ch1, ch2}, 3);
      check(hyst == 1'b1, "R8 R7 inhibit set at boundary", int'(hyst), 1);
    end

    // R9: quarter change mid-period
    do_reset(1'b0, 1'b0, 8'd4);
    wait_ch1();
    @(negedge clk);
    @(negedge clk);
    quarter = 8'd6;
    begin
      int len;
      len = 2;
      for (int t = 2; t < 60; t++) begin
        if (ch1) break;
        len++;
        @(negedge clk);
      end
      check(len == 16, "R9 running period length kept", len, 16);
    end
    scan(per, off, n2, hy);
    check(per == 24, "R9 new period after boundary", per, 24);
    check(off == 12, "R9 R5 offset follows new quarter", off, 12);

    // R2: pulse width one tick
    do_reset(1'b1, 1'b1, 8'd4);
    wait_ch1();
    @(negedge clk);
    check(!ch1, "R2 channel-1 pulse one tick", int'(ch1), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule